// File: doc/BRIEF.md
# Mode-dependent vertical period generator

This block produces the vertical drive strobe for a frame-readout image sensor timing chain. It runs a two-level count on the pixel clock: a horizontal counter of `H_LEN` clocks per line, and a line counter. Every vertical period is a whole number of lines followed by a residual run of pixel clocks, so the period is not a multiple of the line length. Both the line count and the residual depend on the selected drive mode and on the video standard.

Mode and standard are sampled only at a period boundary. A change on the inputs part way through a period never alters the period in progress. The alternating frame mode flips between field A and field B on each period. Two further frame modes hold a fixed field. The strobe goes low for `VD_W` clocks at the start of each period, so its falling edge marks the first clock of the new period.

Top module: `vdrive_period_gen`

## Requirements
- R1: With `pal_i`=0 the clocks between consecutive `vd_no` falling edges equal lines*H_LEN+residual: draft (mode 0) 224 lines + 1372, AF1 (mode 1) 112 + 1372, AF2 (mode 2) 56 + 686, every frame mode (3, 4, 5) 1012 + 1672.
- R2: With `pal_i`=1 the period is draft 269 lines + 2039, AF1 134 + 2354, AF2 67 + 1178, every frame mode 944 + 464.
- R3: Mode codes 6 and 7 are reserved and give the draft-mode period of the selected standard.
- R4: `vd_no` is low for exactly `VD_W` clocks, starting on the first clock of each period.
- R5: `line_o` is 0 on the first clock of a period and counts up once per `H_LEN` clocks. During the residual clocks it holds the mode's line count, which is its largest value.
- R6: `mode_i` and `pal_i` are sampled only on the last clock of a period. A change during a period leaves that period's length unchanged.
- R7: `field_b_o` (1 = field B) is 1 in mode 5 and 0 in modes 4, 0, 1, 2, 6 and 7. In mode 3 the field is A in the first period after entry from any other mode, and it inverts on every later period in mode 3.
- R8: While `rst_ni` is low, `vd_no`=0, `line_o`=0 and `field_b_o`=0. The first period after reset is NTSC draft (4*... per R1 with draft values) whatever the inputs, and it starts on the first clock after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Requested drive mode code |
| pal_i | input | 1 | Standard select: 0 NTSC-like, 1 PAL-like |
| vd_no | output | 1 | Vertical drive strobe, active low |
| line_o | output | 10 | Line index within the current period |
| field_b_o | output | 1 | Field flag: 0 = A, 1 = B |

## Verification
The period boundary is the single cycle where three things happen at once. The counters wrap, a new mode and standard are latched, and the field flag either inverts or is forced. A mode change that lands in the same cycle as a wrap is the case most likely to corrupt the next period. The bench changes `mode_i` and `pal_i` just after each strobe edge. It then checks two lengths: the period already running must keep the old length, and the following period must have the new one. It also checks that the field flag, the line index and the strobe all switch together on the falling edge. A reset asserted in mid-period, while the inputs request alternating frame mode, checks that the first period after release is NTSC draft, and that the next period starts on field A.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  localparam int MODE_W  = 3;
  localparam int LINE_W  = 10;
  localparam int RES_W   = 12;
  localparam int RES_MAX = 2354;

  localparam logic [MODE_W-1:0] MD_DRAFT   = 3'd0;
  localparam logic [MODE_W-1:0] MD_AF1     = 3'd1;
  localparam logic [MODE_W-1:0] MD_AF2     = 3'd2;
  localparam logic [MODE_W-1:0] MD_FRM_ALT = 3'd3;
  localparam logic [MODE_W-1:0] MD_FRM_A   = 3'd4;
  localparam logic [MODE_W-1:0] MD_FRM_B   = 3'd5;

  typedef struct packed {
    logic [LINE_W-1:0] lines;
    logic [RES_W-1:0]  extra;
  } period_t;

  // reserved codes fall back to draft timing
  function automatic period_t period_of(input logic [MODE_W-1:0] m, input logic pal);
    period_t p;
    case (m)
      MD_AF1: begin
        p.lines = pal ? 10'd134 : 10'd112;
        p.extra = pal ? 12'd2354 : 12'd1372;
      end
      MD_AF2: begin
        p.lines = pal ? 10'd67 : 10'd56;
        p.extra = pal ? 12'd1178 : 12'd686;
      end
      MD_FRM_ALT, MD_FRM_A, MD_FRM_B: begin
        p.lines = pal ? 10'd944 : 10'd1012;
        p.extra = pal ? 12'd464 : 12'd1672;
      end
      default: begin
        p.lines = pal ? 10'd269 : 10'd224;
        p.extra = pal ? 12'd2039 : 12'd1372;
      end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/vpg_cfg_latch.sv
module vpg_cfg_latch
  import vpg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wrap_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pal_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              pal_o,
  output logic              field_b_o
);
  logic [MODE_W-1:0] mode_q;
  logic              pal_q;
  logic              field_q;
  logic              field_d;

  always_comb begin
    case (mode_i)
      MD_FRM_ALT: field_d = (mode_q == MD_FRM_ALT) ? ~field_q : 1'b0;
      MD_FRM_B:   field_d = 1'b1;
      default:    field_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MD_DRAFT;
      pal_q   <= 1'b0;
      field_q <= 1'b0;
    end else if (wrap_i) begin
      mode_q  <= mode_i;
      pal_q   <= pal_i;
      field_q <= field_d;
    end
  end

  assign mode_o    = mode_q;
  assign pal_o     = pal_q;
  assign field_b_o = field_q;

  assert_cfg_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> ($stable(mode_q) && $stable(pal_q) && $stable(field_q)));

  assert_field_alt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && mode_q == MD_FRM_ALT && mode_i == MD_FRM_ALT) |=> (field_q != $past(field_q)));

  assert_field_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && mode_i == MD_FRM_B) |=> field_q);

  assert_field_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && mode_i != MD_FRM_B && mode_i != MD_FRM_ALT) |=> !field_q);
endmodule

// File: rtl/vpg_line_counter.sv
module vpg_line_counter
  import vpg_pkg::*;
#(
  parameter int H_LEN = 1560,
  parameter int CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pal_i,
  output logic [LINE_W-1:0] line_o,
  output logic              wrap_o
);
  period_t           per;
  logic [CNT_W-1:0]  h_q;
  logic [LINE_W-1:0] line_q;
  logic              in_tail;
  logic [CNT_W-1:0]  h_last;
  logic              line_end;

  assign per      = period_of(mode_i, pal_i);
  assign in_tail  = (line_q == per.lines);
  // residual segment may be longer than a line
  assign h_last   = in_tail ? (CNT_W'(per.extra) - CNT_W'(1)) : CNT_W'(H_LEN - 1);
  assign line_end = (h_q == h_last);
  assign wrap_o   = in_tail && line_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q    <= '0;
      line_q <= '0;
    end else if (line_end) begin
      h_q    <= '0;
      line_q <= wrap_o ? '0 : line_q + LINE_W'(1);
    end else begin
      h_q    <= h_q + CNT_W'(1);
    end
  end

  assign line_o = line_q;

  assert_line_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q <= per.lines);

  assert_wrap_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (line_q == '0 && h_q == '0));
endmodule

// File: rtl/vpg_vd_shaper.sv
module vpg_vd_shaper #(
  parameter int VD_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  output logic vd_no
);
  localparam int CW = $clog2(VD_W + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CW'(VD_W);
    else if (wrap_i)         cnt_q <= CW'(VD_W);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign vd_no = (cnt_q == '0);

  assert_vd_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> !vd_no);

  assert_vd_fall_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vd_no) |-> $past(wrap_i));

  assert_vd_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |-> vd_no);
endmodule

// File: rtl/vdrive_period_gen.sv
module vdrive_period_gen
  import vpg_pkg::*;
#(
  parameter int H_LEN = 1560,
  parameter int VD_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pal_i,
  output logic              vd_no,
  output logic [LINE_W-1:0] line_o,
  output logic              field_b_o
);
  localparam int HMAX  = (H_LEN > RES_MAX) ? H_LEN : RES_MAX;
  localparam int CNT_W = $clog2(HMAX + 1);

  logic [MODE_W-1:0] mode_q;
  logic              pal_q;
  logic              wrap;

  vpg_cfg_latch u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap_i    (wrap),
    .mode_i    (mode_i),
    .pal_i     (pal_i),
    .mode_o    (mode_q),
    .pal_o     (pal_q),
    .field_b_o (field_b_o)
  );

  vpg_line_counter #(.H_LEN(H_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_q),
    .pal_i  (pal_q),
    .line_o (line_o),
    .wrap_o (wrap)
  );

  vpg_vd_shaper #(.VD_W(VD_W)) u_vd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wrap_i (wrap),
    .vd_no  (vd_no)
  );
endmodule

// File: tb/vdrive_period_gen_tb.sv
module vdrive_period_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 4;
  localparam int VDW = 8;
  localparam int NV = 12;
  localparam int LIMIT = 195000;

  localparam int V_MODE [NV]  = '{0, 1, 2, 4, 5, 0, 1, 2, 4, 5, 3, 7};
  localparam int V_PAL  [NV]  = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 1};
  localparam int V_LINES[NV]  = '{224, 112, 56, 1012, 1012, 269, 134, 67, 944, 944, 1012, 269};
  localparam int V_EXTRA[NV]  = '{1372, 1372, 686, 1672, 1672, 2039, 2354, 1178, 464, 464, 1672, 2039};
  localparam int V_FIELD[NV]  = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       pal = 1'b0;
  logic       vd;
  logic [9:0] line;
  logic       field_b;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nfalls = 0;
  int fall_cyc = 0;
  int last_period = 0;
  int max_line = 0;
  int last_max = 0;
  int low_run = 0;
  int last_low = 0;
  logic vd_d = 1'b0;

  vdrive_period_gen #(.H_LEN(H), .VD_W(VDW)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mode_i    (mode),
    .pal_i     (pal),
    .vd_no     (vd),
    .line_o    (line),
    .field_b_o (field_b)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (vd_d && !vd) begin
      last_period = cyc - fall_cyc;
      fall_cyc = cyc;
      nfalls++;
      last_max = max_line;
      max_line = int'(line);
    end else if (int'(line) > max_line) begin
      max_line = int'(line);
    end
    if (!vd_d && vd) begin
      last_low = low_run;
      low_run = 0;
    end
    if (!vd) low_run++;
    vd_d = vd;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fall();
    int n0 = nfalls;
    wait (nfalls != n0);
  endtask

  initial begin
    while (cyc < LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int prev_len = 0;
    bit first = 1'b1;
    int rel = 0;

    repeat (3) @(negedge clk);
    // R8 reset state
    check(vd == 1'b0, "R8 vd", int'(vd), 0);
    check(line == 10'd0, "R8 line", int'(line), 0);
    check(field_b == 1'b0, "R8 field", int'(field_b), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      int exp_len;
      string req;
      @(negedge clk);
      mode = 3'(V_MODE[i]);
      pal  = V_PAL[i][0];
      wait_fall();
      // R6: period running at the input change keeps its old length
      if (!first) check(last_period == prev_len, "R6", last_period, prev_len);
      check(int'(field_b) == V_FIELD[i], "R7", int'(field_b), V_FIELD[i]);
      check(line == 10'd0, "R5 start", int'(line), 0);
      check(vd == 1'b0, "R4 start", int'(vd), 0);
      wait_fall();
      exp_len = V_LINES[i] * H + V_EXTRA[i];
      req = (V_MODE[i] > 5) ? "R3" : (V_PAL[i] != 0 ? "R2" : "R1");
      check(last_period == exp_len, req, last_period, exp_len);
      check(last_max == V_LINES[i], "R5 max", last_max, V_LINES[i]);
      check(last_low == VDW, "R4 width", last_low, VDW);
      prev_len = exp_len;
      first = 1'b0;
    end

    // R7 alternating frame mode, PAL, entered from reserved mode
    @(negedge clk);
    mode = 3'd3;
    pal  = 1'b1;
    wait_fall();
    check(field_b == 1'b0, "R7 alt first A", int'(field_b), 0);
    wait_fall();
    check(field_b == 1'b1, "R7 alt B", int'(field_b), 1);
    check(last_period == 944 * H + 464, "R2 alt", last_period, 944 * H + 464);
    wait_fall();
    check(field_b == 1'b0, "R7 alt A again", int'(field_b), 0);
    check(last_period == 944 * H + 464, "R2 alt B", last_period, 944 * H + 464);

    // R8 mid-period reset while inputs request alternating frame mode
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(vd == 1'b0 && line == 10'd0 && field_b == 1'b0, "R8 async",
          int'({vd, field_b}) + int'(line), 0);
    @(negedge clk);
    rel = cyc;
    rst_n = 1'b1;
    wait_fall();
    check(fall_cyc - rel == 224 * H + 1372, "R8 first period", fall_cyc - rel, 224 * H + 1372);
    check(field_b == 1'b0, "R7 entry A", int'(field_b), 0);
    wait_fall();
    check(last_period == 944 * H + 464, "R2 after reset", last_period, 944 * H + 464);
    check(field_b == 1'b1, "R7 toggle", int'(field_b), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule